// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block sits beside one processor and decides which single interrupt, if any, is presented to it. It holds five pieces of state: the processor's current priority threshold, an inter-processor request priority, the number of the source now pending, that source's priority, and a flag that records a refused delivery. Lower numbers mean more favoured. The interrupt-request output goes high when a source is pending and its priority beats the threshold.

The source controller offers interrupts over a valid/ready port. The presenter either takes an offer, which may displace the one already pending, or refuses it. A refusal sets the resend flag. The processor issues four commands on a plain command port: accept, set threshold, set request priority, and end of interrupt. The presenter answers through one-cycle pulses: an accept result word, a reject carrying a displaced source number, a resend request, an end-of-interrupt carrying a source number, and an offer-refused flag. An inter-processor request appears as the reserved source number given by `IPI_SRC` (default 2) and is never reported back.

The command port has no back-pressure: every `cmd_valid` cycle is executed. The offer port uses `offer_valid`/`offer_ready`. `offer_ready` is low in any cycle that carries a command. Once the source raises `offer_valid`, it must hold `offer_valid`, `offer_src` and `offer_prio` steady until a cycle in which `offer_ready` is high. All outputs except `offer_ready` and `irq_req` are registered and appear one cycle after the command or offer that produced them.

Top module: `irq_presenter`

## Requirements
- R1: After reset the threshold is 0x00, the request priority 0xFF, the pending priority 0xFF, the pending source 0 and the resend flag clear. As a result `irq_req` is low and a first accept returns 0x00000000.
- R2: `irq_req` is high exactly when the pending source is non-zero and the pending priority is numerically below the threshold.
- R3: An offer with priority p is taken when the threshold, the request priority and the pending priority are all greater than p. Taking it replaces the pending source and pending priority, and the source it displaces is emitted as a reject.
- R4: A refused offer sets the resend flag and pulses `offer_refused` for one cycle.
- R5: Accept (`cmd_op`=0) returns the threshold in bits 31:24 and the pending source in bits 23:0 of `xirr_data`. If the pending source was non-zero, the threshold then takes the pending priority, the pending priority becomes 0xFF and the pending source 0. Otherwise nothing changes.
- R6: Set request priority (`cmd_op`=1, value in `cmd_data[7:0]`) always loads it. If the new value is below the threshold and not above the pending priority, the old pending source is rejected, the pending priority takes the new value and the pending source becomes `IPI_SRC`.
- R7: When set request priority raises the value numerically, the resend flag is cleared, and `resend_req` pulses if the flag was set.
- R8: Set threshold (`cmd_op`=2, value in `cmd_data[7:0]`) with the current value changes no state and emits nothing.
- R9: Set threshold to a larger value loads it. If the request priority is below the new threshold and not above the pending priority, `IPI_SRC` becomes pending at the request priority. The resend flag is then cleared, with a `resend_req` pulse if it was set.
- R10: Set threshold to a smaller value loads it. If the new value is not above the pending priority, the pending source is rejected and cleared and the pending priority becomes 0xFF.
- R11: End of interrupt (`cmd_op`=3) applies `cmd_data[31:24]` through the R9 rule, whatever its relation to the current threshold. It emits `eoi_valid` with `cmd_data[23:0]` unless that field equals `IPI_SRC`.
- R12: A displaced source numbered 0 or `IPI_SRC` produces no `reject_valid` pulse.
- R13: A command and an offer in the same cycle run the command first: `offer_ready` is low in that cycle, and the held offer is taken in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Processor command present |
| cmd_op | input | 2 | 0 accept, 1 set request priority, 2 set threshold, 3 end of interrupt |
| cmd_data | input | 32 | Command operand (priority in 7:0, or result-format word) |
| offer_valid | input | 1 | Source controller offers an interrupt |
| offer_ready | output | 1 | Offer accepted for evaluation this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| offer_refused | output | 1 | Pulse: last offer was refused |
| irq_req | output | 1 | Interrupt request to the processor |
| xirr_valid | output | 1 | Pulse: accept result valid |
| xirr_data | output | 32 | Threshold in 31:24, pending source in 23:0 |
| reject_valid | output | 1 | Pulse: a source was displaced |
| reject_src | output | 24 | Displaced source number |
| resend_req | output | 1 | Pulse: ask the source controller to resend |
| eoi_valid | output | 1 | Pulse: end of interrupt for a source |
| eoi_src | output | 24 | Source receiving the end of interrupt |

## Verification
Some properties are checked on every cycle. The offer-hold rule and the ordering of command before offer are checked this way. So are the take and refuse outcomes of an offer, the state clearing after a successful accept, the no-effect case of an equal threshold, the tie between a resend pulse and the earlier resend flag, and the filtering of reserved numbers out of reject pulses. Only the bench's sweeps can show the full arithmetic. These sweeps cover many combinations of threshold, request priority and offered priority, checking which source ends up pending, which source is rejected, when the request line rises and what each accept returns, through chains of up to a dozen commands.

// File: rtl/irq_presenter_pkg.sv
package irq_presenter_pkg;

  typedef enum logic [1:0] {
    OP_ACCEPT   = 2'd0,
    OP_SET_MFRR = 2'd1,
    OP_SET_CPPR = 2'd2,
    OP_EOI      = 2'd3
  } ipr_op_e;

endpackage

// File: rtl/ipr_arbiter.sv
module ipr_arbiter #(
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              offer_valid,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  output logic              offer_ready,
  output logic              cmd_go,
  output logic              offer_go
);

  // processor command always wins the cycle
  assign offer_ready = !cmd_valid;
  assign cmd_go      = cmd_valid;
  assign offer_go    = offer_valid && !cmd_valid;

  // R13
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offer_valid && !offer_ready |=> offer_valid && $stable(offer_src) && $stable(offer_prio));

endmodule

// File: rtl/ipr_step.sv
module ipr_step
  import irq_presenter_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  ipr_op_e                  cmd_op,
  input  logic                     cmd_go,
  input  logic [PRIO_W+SRC_W-1:0]  cmd_data,
  input  logic                     offer_go,
  input  logic [SRC_W-1:0]         offer_src,
  input  logic [PRIO_W-1:0]        offer_prio,
  input  logic [PRIO_W-1:0]        cppr,
  input  logic [PRIO_W-1:0]        mfrr,
  input  logic [PRIO_W-1:0]        pend,
  input  logic [SRC_W-1:0]         xisr,
  input  logic                     need,
  output logic [PRIO_W-1:0]        n_cppr,
  output logic [PRIO_W-1:0]        n_mfrr,
  output logic [PRIO_W-1:0]        n_pend,
  output logic [SRC_W-1:0]         n_xisr,
  output logic                     n_need,
  output logic                     o_xirr_v,
  output logic [PRIO_W+SRC_W-1:0]  o_xirr,
  output logic                     o_rej_v,
  output logic [SRC_W-1:0]         o_rej_src,
  output logic                     o_resend,
  output logic                     o_eoi_v,
  output logic [SRC_W-1:0]         o_eoi_src,
  output logic                     o_refused
);

  localparam int XIRR_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] LEAST  = {PRIO_W{1'b1}};
  localparam logic [SRC_W-1:0]  IPI_ID = SRC_W'(IPI_SRC);

  logic [SRC_W-1:0]  disp;
  logic [PRIO_W-1:0] arg, top, lower_val;
  logic              lower_en;

  assign arg = cmd_data[PRIO_W-1:0];
  assign top = cmd_data[XIRR_W-1 -: PRIO_W];

  always_comb begin
    n_cppr    = cppr;
    n_mfrr    = mfrr;
    n_pend    = pend;
    n_xisr    = xisr;
    n_need    = need;
    disp      = '0;
    lower_en  = 1'b0;
    lower_val = top;
    o_xirr_v  = 1'b0;
    o_xirr    = {cppr, xisr};
    o_resend  = 1'b0;
    o_eoi_v   = 1'b0;
    o_eoi_src = cmd_data[SRC_W-1:0];
    o_refused = 1'b0;

    if (cmd_go) begin
      unique case (cmd_op)
        OP_ACCEPT: begin
          o_xirr_v = 1'b1;
          if (xisr != '0) begin
            n_cppr = pend;
            n_pend = LEAST;
            n_xisr = '0;
          end
        end
        OP_SET_CPPR: begin
          if (arg > cppr) begin
            lower_en  = 1'b1;
            lower_val = arg;
          end else if (arg < cppr) begin
            n_cppr = arg;
            if (arg <= pend) begin
              disp   = xisr;
              n_xisr = '0;
              n_pend = LEAST;
            end
          end
        end
        OP_SET_MFRR: begin
          n_mfrr = arg;
          if (arg < cppr && arg <= pend) begin
            disp   = xisr;
            n_pend = arg;
            n_xisr = IPI_ID;
          end
          if (arg > mfrr) begin
            o_resend = need;
            n_need   = 1'b0;
          end
        end
        default: begin
          lower_en  = 1'b1;
          lower_val = top;
          o_eoi_v   = (cmd_data[SRC_W-1:0] != IPI_ID);
        end
      endcase
    end else if (offer_go) begin
      if (cppr > offer_prio && mfrr > offer_prio && pend > offer_prio) begin
        disp   = xisr;
        n_xisr = offer_src;
        n_pend = offer_prio;
      end else begin
        n_need    = 1'b1;
        o_refused = 1'b1;
      end
    end

    // shared threshold-lowering path (set threshold up, end of interrupt)
    if (lower_en) begin
      n_cppr = lower_val;
      if (mfrr < lower_val && mfrr <= pend) begin
        disp   = xisr;
        n_pend = mfrr;
        n_xisr = IPI_ID;
      end
      o_resend = need;
      n_need   = 1'b0;
    end
  end

  assign o_rej_v   = (disp != '0) && (disp != IPI_ID);
  assign o_rej_src = disp;

endmodule

// File: rtl/ipr_core_regs.sv
module ipr_core_regs
  import irq_presenter_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_go,
  input  ipr_op_e                  cmd_op,
  input  logic [PRIO_W-1:0]        cmd_arg,
  input  logic                     offer_go,
  input  logic [PRIO_W-1:0]        offer_prio,
  input  logic [PRIO_W-1:0]        n_cppr,
  input  logic [PRIO_W-1:0]        n_mfrr,
  input  logic [PRIO_W-1:0]        n_pend,
  input  logic [SRC_W-1:0]         n_xisr,
  input  logic                     n_need,
  input  logic                     o_xirr_v,
  input  logic [PRIO_W+SRC_W-1:0]  o_xirr,
  input  logic                     o_rej_v,
  input  logic [SRC_W-1:0]         o_rej_src,
  input  logic                     o_resend,
  input  logic                     o_eoi_v,
  input  logic [SRC_W-1:0]         o_eoi_src,
  input  logic                     o_refused,
  output logic [PRIO_W-1:0]        cppr,
  output logic [PRIO_W-1:0]        mfrr,
  output logic [PRIO_W-1:0]        pend,
  output logic [SRC_W-1:0]         xisr,
  output logic                     need,
  output logic                     irq_req,
  output logic                     xirr_valid,
  output logic [PRIO_W+SRC_W-1:0]  xirr_data,
  output logic                     reject_valid,
  output logic [SRC_W-1:0]         reject_src,
  output logic                     resend_req,
  output logic                     eoi_valid,
  output logic [SRC_W-1:0]         eoi_src,
  output logic                     offer_refused
);

  localparam logic [PRIO_W-1:0] LEAST  = {PRIO_W{1'b1}};
  localparam logic [SRC_W-1:0]  IPI_ID = SRC_W'(IPI_SRC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cppr <= '0;
      mfrr <= LEAST;
      pend <= LEAST;
      xisr <= '0;
      need <= 1'b0;
    end else begin
      cppr <= n_cppr;
      mfrr <= n_mfrr;
      pend <= n_pend;
      xisr <= n_xisr;
      need <= n_need;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xirr_valid    <= 1'b0;
      xirr_data     <= '0;
      reject_valid  <= 1'b0;
      reject_src    <= '0;
      resend_req    <= 1'b0;
      eoi_valid     <= 1'b0;
      eoi_src       <= '0;
      offer_refused <= 1'b0;
    end else begin
      xirr_valid    <= o_xirr_v;
      xirr_data     <= o_xirr;
      reject_valid  <= o_rej_v;
      reject_src    <= o_rej_src;
      resend_req    <= o_resend;
      eoi_valid     <= o_eoi_v;
      eoi_src       <= o_eoi_src;
      offer_refused <= o_refused;
    end
  end

  assign irq_req = (xisr != '0) && (pend < cppr);

  // R5
  accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && cmd_op == OP_ACCEPT && xisr != '0
    |=> xisr == '0 && pend == LEAST && cppr == $past(pend));

  // R8
  cppr_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_go && cmd_op == OP_SET_CPPR && cmd_arg == cppr
    |=> $stable(cppr) && $stable(pend) && $stable(xisr) && $stable(need)
        && !resend_req && !reject_valid);

  // R3
  offer_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offer_go && offer_prio < cppr && offer_prio < mfrr && offer_prio < pend
    |=> pend == $past(offer_prio) && !offer_refused);

  // R4
  offer_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    offer_go && !(offer_prio < cppr && offer_prio < mfrr && offer_prio < pend)
    |=> need && offer_refused);

  // R7
  resend_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resend_req |-> $past(need) && !need);

  // R12
  reject_filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject_valid |-> reject_src != '0 && reject_src != IPI_ID);

endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irq_presenter_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cmd_valid,
  input  logic [1:0]               cmd_op,
  input  logic [PRIO_W+SRC_W-1:0]  cmd_data,
  input  logic                     offer_valid,
  output logic                     offer_ready,
  input  logic [SRC_W-1:0]         offer_src,
  input  logic [PRIO_W-1:0]        offer_prio,
  output logic                     offer_refused,
  output logic                     irq_req,
  output logic                     xirr_valid,
  output logic [PRIO_W+SRC_W-1:0]  xirr_data,
  output logic                     reject_valid,
  output logic [SRC_W-1:0]         reject_src,
  output logic                     resend_req,
  output logic                     eoi_valid,
  output logic [SRC_W-1:0]         eoi_src
);

  localparam int XIRR_W = PRIO_W + SRC_W;

  ipr_op_e            op;
  logic               cmd_go, offer_go;
  logic [PRIO_W-1:0]  cppr, mfrr, pend, n_cppr, n_mfrr, n_pend;
  logic [SRC_W-1:0]   xisr, n_xisr, o_rej_src, o_eoi_src;
  logic               need, n_need;
  logic               o_xirr_v, o_rej_v, o_resend, o_eoi_v, o_refused;
  logic [XIRR_W-1:0]  o_xirr;

  assign op = ipr_op_e'(cmd_op);

  ipr_arbiter #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_arb (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .offer_valid (offer_valid),
    .offer_src   (offer_src),
    .offer_prio  (offer_prio),
    .offer_ready (offer_ready),
    .cmd_go      (cmd_go),
    .offer_go    (offer_go)
  );

  ipr_step #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_step (
    .cmd_op     (op),
    .cmd_go     (cmd_go),
    .cmd_data   (cmd_data),
    .offer_go   (offer_go),
    .offer_src  (offer_src),
    .offer_prio (offer_prio),
    .cppr       (cppr),
    .mfrr       (mfrr),
    .pend       (pend),
    .xisr       (xisr),
    .need       (need),
    .n_cppr     (n_cppr),
    .n_mfrr     (n_mfrr),
    .n_pend     (n_pend),
    .n_xisr     (n_xisr),
    .n_need     (n_need),
    .o_xirr_v   (o_xirr_v),
    .o_xirr     (o_xirr),
    .o_rej_v    (o_rej_v),
    .o_rej_src  (o_rej_src),
    .o_resend   (o_resend),
    .o_eoi_v    (o_eoi_v),
    .o_eoi_src  (o_eoi_src),
    .o_refused  (o_refused)
  );

  ipr_core_regs #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_go        (cmd_go),
    .cmd_op        (op),
    .cmd_arg       (cmd_data[PRIO_W-1:0]),
    .offer_go      (offer_go),
    .offer_prio    (offer_prio),
    .n_cppr        (n_cppr),
    .n_mfrr        (n_mfrr),
    .n_pend        (n_pend),
    .n_xisr        (n_xisr),
    .n_need        (n_need),
    .o_xirr_v      (o_xirr_v),
    .o_xirr        (o_xirr),
    .o_rej_v       (o_rej_v),
    .o_rej_src     (o_rej_src),
    .o_resend      (o_resend),
    .o_eoi_v       (o_eoi_v),
    .o_eoi_src     (o_eoi_src),
    .o_refused     (o_refused),
    .cppr          (cppr),
    .mfrr          (mfrr),
    .pend          (pend),
    .xisr          (xisr),
    .need          (need),
    .irq_req       (irq_req),
    .xirr_valid    (xirr_valid),
    .xirr_data     (xirr_data),
    .reject_valid  (reject_valid),
    .reject_src    (reject_src),
    .resend_req    (resend_req),
    .eoi_valid     (eoi_valid),
    .eoi_src       (eoi_src),
    .offer_refused (offer_refused)
  );

endmodule

// File: tb/irq_presenter_test.sv
`timescale 1ns/1ps
module irq_presenter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [31:0] cmd_data = '0;
  logic        offer_valid = 1'b0;
  logic        offer_ready;
  logic [23:0] offer_src = '0;
  logic [7:0]  offer_prio = '0;
  logic        offer_refused, irq_req, xirr_valid, reject_valid, resend_req, eoi_valid;
  logic [31:0] xirr_data;
  logic [23:0] reject_src, eoi_src;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench model of the presenter state
  logic [7:0]  m_cppr, m_mfrr, m_pend;
  logic [23:0] m_xisr;
  logic        m_need;
  // expected pulses after one operation
  logic        e_xv, e_rv, e_res, e_ev, e_ref;
  logic [31:0] e_x;
  logic [23:0] e_rs, e_es;

  always #2 clk = ~clk;

  irq_presenter uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .offer_valid(offer_valid), .offer_ready(offer_ready), .offer_src(offer_src),
    .offer_prio(offer_prio), .offer_refused(offer_refused), .irq_req(irq_req),
    .xirr_valid(xirr_valid), .xirr_data(xirr_data), .reject_valid(reject_valid),
    .reject_src(reject_src), .resend_req(resend_req), .eoi_valid(eoi_valid), .eoi_src(eoi_src)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h want %h", tag, act, exp);
    end
  endtask

  task automatic clear_exp();
    e_xv = 0; e_rv = 0; e_res = 0; e_ev = 0; e_ref = 0;
    e_x = '0; e_rs = '0; e_es = '0;
  endtask

  task automatic model_reset();
    m_cppr = 8'h00; m_mfrr = 8'hFF; m_pend = 8'hFF; m_xisr = '0; m_need = 0;
    clear_exp();
  endtask

  task automatic finish_disp(input logic [23:0] d);
    // R12: reserved numbers are never reported
    if (d != 24'd0 && d != 24'd2) begin e_rv = 1; e_rs = d; end
  endtask

  task automatic model_cmd(input logic [1:0] op, input logic [31:0] d);
    logic [23:0] disp;
    logic [7:0]  a, lv;
    logic        lower;
    clear_exp();
    disp = '0; lower = 0; a = d[7:0]; lv = d[31:24];
    case (op)
      2'd0: begin  // R5
        e_xv = 1; e_x = {m_cppr, m_xisr};
        if (m_xisr != 0) begin m_cppr = m_pend; m_pend = 8'hFF; m_xisr = 0; end
      end
      2'd1: begin  // R6, R7
        if (a < m_cppr && a <= m_pend) begin disp = m_xisr; m_pend = a; m_xisr = 24'd2; end
        if (a > m_mfrr) begin e_res = m_need; m_need = 0; end
        m_mfrr = a;
      end
      2'd2: begin  // R8, R9, R10
        if (a > m_cppr) begin lower = 1; lv = a; end
        else if (a < m_cppr) begin
          m_cppr = a;
          if (a <= m_pend) begin disp = m_xisr; m_xisr = 0; m_pend = 8'hFF; end
        end
      end
      default: begin  // R11
        lower = 1;
        if (d[23:0] != 24'd2) begin e_ev = 1; e_es = d[23:0]; end
      end
    endcase
    if (lower) begin
      m_cppr = lv;
      if (m_mfrr < lv && m_mfrr <= m_pend) begin disp = m_xisr; m_pend = m_mfrr; m_xisr = 24'd2; end
      e_res = m_need; m_need = 0;
    end
    finish_disp(disp);
  endtask

  task automatic model_offer(input logic [23:0] s, input logic [7:0] p);
    clear_exp();
    if (p < m_cppr && p < m_mfrr && p < m_pend) begin  // R3
      finish_disp(m_xisr); m_xisr = s; m_pend = p;
    end else begin  // R4
      m_need = 1; e_ref = 1;
    end
  endtask

  task automatic compare(input string tag);
    chk({31'd0, irq_req}, {31'd0, (m_xisr != 0) && (m_pend < m_cppr)}, {tag, "/R2 irq"});
    chk({31'd0, xirr_valid}, {31'd0, e_xv}, {tag, " xirr_valid"});
    if (e_xv) chk(xirr_data, e_x, {tag, " xirr_data"});
    chk({31'd0, reject_valid}, {31'd0, e_rv}, {tag, "/R12 reject_valid"});
    if (e_rv) chk({8'd0, reject_src}, {8'd0, e_rs}, {tag, " reject_src"});
    chk({31'd0, resend_req}, {31'd0, e_res}, {tag, " resend_req"});
    chk({31'd0, eoi_valid}, {31'd0, e_ev}, {tag, " eoi_valid"});
    if (e_ev) chk({8'd0, eoi_src}, {8'd0, e_es}, {tag, " eoi_src"});
    chk({31'd0, offer_refused}, {31'd0, e_ref}, {tag, " offer_refused"});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; cmd_valid = 0; offer_valid = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    model_reset();
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [31:0] d, input string tag);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_data = d;
    model_cmd(op, d);
    @(negedge clk);
    cmd_valid = 0;
    compare(tag);
  endtask

  task automatic run_offer(input logic [23:0] s, input logic [7:0] p, input string tag);
    @(negedge clk);
    offer_valid = 1; offer_src = s; offer_prio = p;
    model_offer(s, p);
    @(negedge clk);
    offer_valid = 0;
    compare(tag);
  endtask

  logic [7:0] vals [7] = '{8'h00, 8'h01, 8'h03, 8'h04, 8'h05, 8'hFE, 8'hFF};

  initial begin
    model_reset();
    do_reset();
    // R1: reset state seen at the ports
    #1;
    chk({31'd0, irq_req}, 32'd0, "R1 irq after reset");
    chk({31'd0, offer_ready}, 32'd1, "R1 offer_ready after reset");
    run_cmd(2'd0, 32'd0, "R1");
    chk(xirr_data, 32'h00000000, "R1 first accept");
    run_offer(24'h000050, 8'h00, "R4");
    run_cmd(2'd1, 32'hFF, "R7");
    run_cmd(2'd2, 32'hFF, "R9");

    // R13: command and offer in one cycle
    do_reset();
    run_cmd(2'd2, 32'h10, "R13");
    @(negedge clk);
    cmd_valid = 1; cmd_op = 2'd1; cmd_data = 32'h08;
    offer_valid = 1; offer_src = 24'h000033; offer_prio = 8'h05;
    #1;
    chk({31'd0, offer_ready}, 32'd0, "R13 ready low with command");
    model_cmd(2'd1, 32'h08);
    @(negedge clk);
    cmd_valid = 0;
    compare("R13 command first");
    #1;
    chk({31'd0, offer_ready}, 32'd1, "R13 ready after command");
    model_offer(24'h000033, 8'h05);
    @(negedge clk);
    offer_valid = 0;
    compare("R13 held offer");

    // R12: displacing an inter-processor request is silent
    do_reset();
    run_cmd(2'd2, 32'h10, "R12");
    run_cmd(2'd1, 32'h04, "R6");
    run_cmd(2'd2, 32'h02, "R12");
    run_cmd(2'd3, 32'hFF000002, "R11");

    // sweep over threshold, request priority and offered priority
    for (int ci = 0; ci < 7; ci++) begin
      for (int mi = 0; mi < 7; mi++) begin
        for (int pi = 0; pi < 7; pi++) begin
          logic [23:0] got;
          do_reset();
          run_cmd(2'd2, {24'd0, vals[ci]}, "R9");
          run_cmd(2'd1, {24'd0, vals[mi]}, "R6");
          run_offer(24'h000100, vals[pi], "R3");
          run_offer(24'h000200, vals[pi] ^ 8'h01, "R4");
          run_cmd(2'd2, {24'd0, vals[ci]}, "R8");
          run_cmd(2'd2, {24'd0, vals[ci] >> 1}, "R10");
          run_cmd(2'd1, 32'hFF, "R7");
          run_cmd(2'd0, 32'd0, "R5");
          got = xirr_data[23:0];
          run_cmd(2'd3, {vals[ci], got}, "R11");
          run_offer(24'h000300, vals[pi], "R3");
          run_cmd(2'd0, 32'd0, "R5");
        end
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout want completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule